// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog counter that sits on a simple register-write bus. Software must keep clearing it. If the count reaches the selected limit first, the block raises an interrupt pulse, a reset-request pulse, or both in two stages. The control register is guarded: a two-word unlock key must come before each accepted control write. A second two-word key, written to the same address, zeroes the count without touching the control fields.

The bus has four word addresses:

- 0: control
- 1: count bits 15:0
- 2: count bits 30:16
- 3: reset-cause status

Reads are combinational. Two resets are provided. `por_n` is an asynchronous power-on reset that clears everything. `sys_rst_n` is a synchronous system reset that clears everything except the reset-cause flag, so software can still see why the system was reset.

Top module: `keyed_watchdog`

## Requirements
- R1: While enable is 0 the 31-bit count reads 0. After the write that sets enable, the count reads 0 in the following cycle and then rises by one on every clock.
- R2: Writing 16'h3333 and then 16'hCCCC to address 0 opens a window for exactly one further address-0 write. That write is stored. The key words themselves are never stored.
- R3: Without an open window, an address-0 write leaves the control fields unchanged. This holds while enabled too, so enable cannot be cleared without a key. Control layout: bit 15 enable, bits 13:12 mode, bit 8 interrupt pending, bits 4:0 limit exponent.
- R4: Writing 16'hAAAA and then 16'h5555 to address 0 zeroes the count and the combined-mode stage flag, and leaves the control fields unchanged.
- R5: While the window is open, 16'hAAAA is stored as control data (enable 1, mode 2'b10, exponent 10, read back as 16'hA00A). It does not start a clear key, so a following 16'h5555 does not zero the count.
- R6: An address-0 write other than the expected second word returns a key in progress to idle. Writes to addresses 1 to 3 do not disturb key progress.
- R7: A timeout occurs when an enabled count equals 2^exponent - 1. The count then restarts at 0 on the next edge. In the cycle after the timeout, mode 2'b01 gives a one-cycle `irq` pulse, mode 2'b10 a one-cycle `wdt_rst` pulse, and mode 2'b00 no pulse.
- R8: Mode 2'b11 pulses `irq` on the first timeout and `wdt_rst` on the second. A clear key between the two makes the next timeout an interrupt again.
- R9: Each `irq` pulse sets the pending bit (address 0, bit 8). An accepted control write with bit 8 set clears it.
- R10: Each `wdt_rst` pulse sets the status bit (address 3, bit 0). This bit survives `sys_rst_n`, and is cleared only by `por_n` or by writing 1 to address 3 bit 0.
- R11: Address 1 reads count bits 15:0. Address 2 reads count bits 30:16 with bit 15 zero.
- R12: If the clear key completes in a timeout cycle, the clear wins: the count goes to 0 and no pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the count advances on every rising edge |
| por_n | input | 1 | Asynchronous power-on reset, active low, clears all state |
| sys_rst_n | input | 1 | Synchronous system reset, active low, spares the status bit |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write word address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 16 | Read data for `rd_addr` |
| irq | output | 1 | One-cycle interrupt pulse |
| wdt_rst | output | 1 | One-cycle system reset request |

## Verification
Two functions can fall in the same cycle: a clear key completing, and a timeout. The bench enables a short limit (exponent 3), then counts cycles so that 16'h5555 is sampled on the edge where the count equals the limit. The result is judged by the count reading 0 right afterwards and the interrupt count staying unchanged. A second overlap is the open unlock window meeting 16'hAAAA; it is judged by the stored control value and by the count not being cleared by the following 16'h5555.

// File: rtl/keyed_watchdog.sv
`timescale 1ns/1ps
module keyed_watchdog (
  input  logic        clk,
  input  logic        por_n,
  input  logic        sys_rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic        irq,
  output logic        wdt_rst
);
  localparam logic [15:0] UL_A = 16'h3333, UL_B = 16'hCCCC;
  localparam logic [15:0] CL_A = 16'hAAAA, CL_B = 16'h5555;
  localparam logic [1:0]  M_IRQ = 2'b01, M_RST = 2'b10, M_BOTH = 2'b11;

  logic        en_q, pend_q, stat_q, stage_q, ul_arm, cl_arm, win_q;
  logic [1:0]  mode_q;
  logic [4:0]  exp_q;
  logic [30:0] cnt_q, limit;
  logic        ctrl_wr, commit, key_wr, unlock_hit, clr_hit, tmo, fire_irq, fire_rst;

  assign ctrl_wr    = wr_en && (wr_addr == 2'd0);
  assign commit     = ctrl_wr && win_q;
  assign key_wr     = ctrl_wr && !win_q;
  assign unlock_hit = key_wr && ul_arm && (wr_data == UL_B);
  assign clr_hit    = key_wr && cl_arm && (wr_data == CL_B);
  assign limit      = 31'((32'd1 << exp_q) - 32'd1);
  assign tmo        = en_q && (cnt_q == limit) && !clr_hit;
  assign fire_irq   = tmo && ((mode_q == M_IRQ) || (mode_q == M_BOTH && !stage_q));
  assign fire_rst   = tmo && ((mode_q == M_RST) || (mode_q == M_BOTH && stage_q));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n || !sys_rst_n) begin
      en_q <= 1'b0; mode_q <= 2'b00; exp_q <= 5'd0; pend_q <= 1'b0;
      stage_q <= 1'b0; ul_arm <= 1'b0; cl_arm <= 1'b0; win_q <= 1'b0;
      cnt_q <= '0; irq <= 1'b0; wdt_rst <= 1'b0;
    end else begin
      irq     <= fire_irq;
      wdt_rst <= fire_rst;
      if (commit) begin
        en_q   <= wr_data[15];
        mode_q <= wr_data[13:12];
        exp_q  <= wr_data[4:0];
        win_q  <= 1'b0;
      end else if (unlock_hit) begin
        win_q <= 1'b1;
      end
      if (key_wr) begin
        ul_arm <= (wr_data == UL_A);
        cl_arm <= (wr_data == CL_A);
      end else if (commit) begin
        ul_arm <= 1'b0;
        cl_arm <= 1'b0;
      end
      if (fire_irq)                  pend_q <= 1'b1;
      else if (commit && wr_data[8]) pend_q <= 1'b0;
      if (clr_hit || !en_q)            stage_q <= 1'b0;
      else if (tmo && mode_q == M_BOTH) stage_q <= !stage_q;
      if (!en_q || clr_hit || tmo) cnt_q <= '0;
      else                         cnt_q <= cnt_q + 31'd1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                                        stat_q <= 1'b0;
    else if (fire_rst)                                 stat_q <= 1'b1;
    else if (wr_en && wr_addr == 2'd3 && wr_data[0])   stat_q <= 1'b0;
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {en_q, 1'b0, mode_q, 3'b000, pend_q, 3'b000, exp_q};
      2'd1:    rd_data = cnt_q[15:0];
      2'd2:    rd_data = {1'b0, cnt_q[30:16]};
      default: rd_data = {15'd0, stat_q};
    endcase
  end

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst_n && en_q && !tmo && !clr_hit && !commit) |=> cnt_q == $past(cnt_q) + 31'd1);
  assert_single_write_R2: assert property (@(posedge clk) disable iff (!por_n)
    (commit && sys_rst_n) |=> !win_q);
  assert_locked_R3: assert property (@(posedge clk) disable iff (!por_n)
    (key_wr && sys_rst_n) |=> $stable({en_q, mode_q, exp_q}));
  assert_clear_R4: assert property (@(posedge clk) disable iff (!por_n)
    (clr_hit && sys_rst_n) |=> (cnt_q == '0) && !stage_q);
  assert_one_pulse_R7: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({irq, wdt_rst}));
  assert_pend_R9: assert property (@(posedge clk) disable iff (!por_n)
    (fire_irq && sys_rst_n) |=> irq && pend_q);
  assert_status_R10: assert property (@(posedge clk) disable iff (!por_n)
    wdt_rst |-> stat_q);
  assert_clear_wins_R12: assert property (@(posedge clk) disable iff (!por_n)
    (clr_hit && sys_rst_n) |=> !irq && !wdt_rst);
endmodule

// File: tb/tb_keyed_watchdog.sv
`timescale 1ns/1ps
module tb_keyed_watchdog;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, por_n, sys_rst_n, wr_en;
  logic [1:0] wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic irq, wdt_rst;

  keyed_watchdog dut (.clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq), .wdt_rst(wdt_rst));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {int cyc; int kind; logic [15:0] val; string req;} item_t;
  item_t q[$];
  int cyc = 0, checks = 0, errors = 0, n_irq = 0, n_rst = 0, e_irq = 0, e_rst = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (por_n) begin
      if (irq) n_irq++;
      if (wdt_rst) n_rst++;
    end
    while (q.size() > 0 && q[0].cyc == cyc) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      act = (it.kind == 0) ? rd_data : (it.kind == 1) ? 16'(n_irq) : 16'(n_rst);
      checks++;
      if (act !== it.val) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.val);
      end
    end
  end

  task automatic push(int kind, logic [15:0] v, string req);
    item_t it;
    it.cyc = cyc; it.kind = kind; it.val = v; it.req = req;
    q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic rd(logic [1:0] a, logic [15:0] v, string req);
    rd_addr = a;
    push(0, v, req);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(2'd0, 16'h3333);
    wr(2'd0, 16'hCCCC);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    por_n = 1'b0; sys_rst_n = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(posedge clk); #1;
    por_n = 1'b1;
    @(posedge clk); #1;
    rd(2'd0, 16'h0000, "R1 reset control");
    rd(2'd1, 16'h0000, "R1 reset count");
    rd(2'd3, 16'h0000, "R10 reset status");
    // R3: no key, write refused
    wr(2'd0, 16'h900A);
    rd(2'd0, 16'h0000, "R3 locked write");
    // R2: unlock then enable, irq mode, exponent 10
    unlock();
    wr(2'd0, 16'h900A);
    rd(2'd0, 16'h900A, "R2 committed write");
    rd(2'd1, 16'd1, "R1 count step 1");
    rd(2'd1, 16'd2, "R1 count step 2");
    wr(2'd0, 16'h0000);
    rd(2'd0, 16'h900A, "R3 second write needs key");
    // R4 clear key
    wr(2'd0, 16'hAAAA);
    wr(2'd0, 16'h5555);
    rd(2'd1, 16'd0, "R4 count cleared");
    rd(2'd0, 16'h900A, "R4 control kept");
    // R6 broken key and foreign address
    wr(2'd0, 16'h3333);
    wr(2'd0, 16'h1234);
    wr(2'd0, 16'hCCCC);
    wr(2'd0, 16'h0000);
    rd(2'd0, 16'h900A, "R6 broken key");
    wr(2'd0, 16'h3333);
    wr(2'd2, 16'hFFFF);
    wr(2'd0, 16'hCCCC);
    wr(2'd0, 16'h000A);
    rd(2'd0, 16'h000A, "R6 other address ignored");
    repeat (3) @(posedge clk); #1;
    rd(2'd1, 16'd0, "R1 disabled holds zero");
    // R5 window open meets AAAA
    unlock();
    wr(2'd0, 16'hAAAA);
    wr(2'd0, 16'h5555);
    rd(2'd1, 16'd1, "R5 no clear after stored AAAA");
    rd(2'd0, 16'hA00A, "R5 AAAA stored");
    unlock();
    wr(2'd0, 16'h0000);
    // R7 and R9: irq mode, exponent 3
    unlock();
    wr(2'd0, 16'h9003);
    repeat (10) @(posedge clk); #1;
    e_irq++;
    push(1, 16'(e_irq), "R7 irq pulse");
    rd(2'd0, 16'h9103, "R9 pending set");
    unlock();
    wr(2'd0, 16'h0100);
    rd(2'd0, 16'h0000, "R9 pending cleared");
    push(2, 16'(e_rst), "R7 no reset in irq mode");
    // R12 clear on timeout cycle
    unlock();
    wr(2'd0, 16'h9003);
    repeat (6) @(posedge clk); #1;
    wr(2'd0, 16'hAAAA);
    wr(2'd0, 16'h5555);
    rd(2'd1, 16'd0, "R12 count zero");
    push(1, 16'(e_irq), "R12 no irq");
    unlock();
    wr(2'd0, 16'h0000);
    // R8 combined mode with clear between stages
    unlock();
    wr(2'd0, 16'hB003);
    repeat (12) @(posedge clk); #1;
    wr(2'd0, 16'hAAAA);
    wr(2'd0, 16'h5555);
    repeat (10) @(posedge clk); #1;
    e_irq += 2;
    push(1, 16'(e_irq), "R8 clear restarts stage");
    push(2, 16'(e_rst), "R8 no reset after clear");
    unlock();
    wr(2'd0, 16'h0100);
    // R8 and R10 combined mode reaching reset
    unlock();
    wr(2'd0, 16'hB003);
    repeat (12) @(posedge clk); #1;
    e_irq++;
    push(1, 16'(e_irq), "R8 first stage irq");
    repeat (7) @(posedge clk); #1;
    e_rst++;
    push(2, 16'(e_rst), "R8 second stage reset");
    rd(2'd3, 16'h0001, "R10 status set");
    sys_rst_n = 1'b0;
    @(posedge clk); #1;
    sys_rst_n = 1'b1;
    rd(2'd3, 16'h0001, "R10 status survives system reset");
    rd(2'd0, 16'h0000, "R10 control reset");
    push(1, 16'(e_irq), "R10 no pulse after reset");
    wr(2'd3, 16'h0001);
    rd(2'd3, 16'h0000, "R10 status write-one clear");
    // R11 high count
    unlock();
    wr(2'd0, 16'h8014);
    repeat (70000) @(posedge clk); #1;
    rd(2'd2, 16'h0001, "R11 high count");
    rd(2'd1, 16'd4465, "R11 low count");
    unlock();
    wr(2'd0, 16'h0000);
    repeat (2) @(posedge clk); #1;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d expected 0 pending items", q.size());
    end
    summary();
  end
endmodule